// File: doc/BRIEF.md
# Dataway Command Decoder for a Trigger and Attention Module

This block receives one dataway command per strobe: a 5-bit function code and a 4-bit subaddress. It turns that command into one registered response cycle. That cycle carries the read word, the X flag (command recognised) and the Q flag (positive response), plus one-cycle action strobes. The strobes clear the strobed input latch, the attention counter and the input-OR counter, and they reset or re-arm the attention request. The block also holds the input-enable mask register. Software writes that register in remote mode; in local mode the front switches supply the mask instead.

The registers it reads live outside the block: the input snapshot, the attention counter, the strobed latch and the OR counter. The block samples them at the clock edge that accepts the command. Any clear strobe it raises is seen by those registers one edge later, so every combined read-and-clear returns the value from before the clear.

The control is a three-state machine:
- `ST_IDLE` waits for `cmd_stb`. Transition *accept*: strobe high in `ST_IDLE`, go to `ST_RESP`.
- `ST_RESP` drives the response for exactly one cycle. Transition *finish*: strobe already low, go to `ST_IDLE`. Transition *linger*: strobe still high, go to `ST_HOLD`.
- `ST_HOLD` waits for the strobe to drop. Transition *release*: go to `ST_IDLE`.

A strobe held high for many cycles therefore runs its command only once.

Top module: `dw_cmd_decoder`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_x`, `rsp_q`, `rd_data` and all action strobes are 0, and in remote mode `mask_o` is 0.
- R2: A `cmd_stb` seen high at a clock edge in `ST_IDLE` produces `rsp_valid`=1 and the response fields during the following cycle only. A strobe held high gives a single response. Outside that cycle all response outputs and strobes are 0.
- R3: Function 0, subaddress 0 returns the effective mask in `rd_data[7:0]`. The effective mask is the mask register in remote mode (`remote_mode`=1) and `sw_mask` in local mode. `mask_o` always shows the effective mask.
- R4: Function 16, subaddress 0 in remote mode loads `wr_data` into the mask register, visible on `mask_o` one cycle after the response cycle, with X=1 and Q=1. In local mode it returns X=1, Q=0 and leaves the mask register unchanged.
- R5: Function 1, subaddress 0 returns `snap_in` in bits 7:0 and `attn_cnt_in` in bits 15:8. Function 1, subaddress 2 returns `snap_in` in bits 7:0 with bits 15:8 zero.
- R6: Function 0, subaddress 1 returns `latch_in`. Function 9, subaddress 1 pulses `clr_latch_o` and returns data 0. Function 2, subaddress 1 returns `latch_in` as sampled at the accept edge and pulses `clr_latch_o` in the same response cycle.
- R7: Function 1, subaddress 1 returns `orc_in`. Function 11, subaddress 1 pulses `clr_orc_o`. Function 4, subaddress 1 returns `orc_in` and pulses `clr_orc_o`.
- R8: Function 11, subaddress 0 pulses `clr_acnt_o`. Function 4, subaddress 0 returns the same word as function 1, subaddress 0 and pulses `clr_acnt_o`.
- R9: At subaddress 0, function 10 pulses `attn_rst_o`, function 26 pulses `attn_en_o`, and function 28 pulses both.
- R10: Function 8, subaddress 0 returns X=1 and Q equal to `attn_present` at the accept edge, with no strobe.
- R11: Every function/subaddress pair not listed in R3 to R10 returns X=0, Q=0 and data 0, raises no strobe and leaves the mask unchanged.
- R12: Every recognised command returns X=1 and Q=1, except the local-mode mask write and the attention test with no attention present. Commands that read nothing return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Command strobe, level |
| cmd_f | input | 5 | Function code |
| cmd_a | input | 4 | Subaddress |
| wr_data | input | MASK_W | Write data for the mask register |
| remote_mode | input | 1 | 1 = mask from register, 0 = mask from switches |
| sw_mask | input | MASK_W | Switch-set enable mask |
| attn_present | input | 1 | Attention request currently raised |
| snap_in | input | MASK_W | Input snapshot register |
| attn_cnt_in | input | CNT_W | Attention counter |
| latch_in | input | LATCH_W | Strobed input latch |
| orc_in | input | ORC_W | Input-OR counter |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_x | output | 1 | Command recognised |
| rsp_q | output | 1 | Positive response |
| rd_data | output | DATA_W | Read word |
| mask_o | output | MASK_W | Effective enable mask |
| clr_latch_o | output | 1 | Clear strobed latch |
| clr_orc_o | output | 1 | Clear OR counter |
| clr_acnt_o | output | 1 | Clear attention counter |
| attn_rst_o | output | 1 | Reset attention request |
| attn_en_o | output | 1 | Re-arm attention request |

## Verification
The bench builds the block with its defaults: an 8-bit mask and snapshot, an 8-bit attention counter, and a 16-bit latch and OR counter, which gives a 16-bit read word. That small size lets it sweep all 512 function/subaddress pairs in both mask modes and at both attention levels. Every read source is driven with a different pattern per command, so a wrong field, a wrong routing choice or a missing clear strobe shows up as a mismatch. Separate runs cover the reset state, a strobe held high for several cycles, and mask write-back in each mode.

// File: rtl/dw_cmd_pkg.sv
package dw_cmd_pkg;

    localparam int F_W = 5;
    localparam int A_W = 4;

    typedef enum logic [2:0] {
        RS_NONE     = 3'd0,
        RS_MASK     = 3'd1,
        RS_SNAP_CNT = 3'd2,
        RS_SNAP     = 3'd3,
        RS_LATCH    = 3'd4,
        RS_ORC      = 3'd5
    } rsel_e;

    typedef struct packed {
        logic  x;
        logic  q;
        rsel_e rsel;
        logic  wr_mask;
        logic  clr_latch;
        logic  clr_orc;
        logic  clr_acnt;
        logic  attn_rst;
        logic  attn_en;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_HOLD = 2'd2
    } state_e;

endpackage

// File: rtl/dw_cmd_table.sv
module dw_cmd_table
    import dw_cmd_pkg::*;
(
    input  logic [F_W-1:0] f,
    input  logic [A_W-1:0] a,
    input  logic           remote,
    input  logic           attn,
    output dec_t           dec
);

    logic a0, a1, a2;

    assign a0 = (a == 4'd0);
    assign a1 = (a == 4'd1);
    assign a2 = (a == 4'd2);

    always_comb begin
        dec = '0;
        case (f)
            5'd0: begin
                if (a0) begin dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_MASK; end
                else if (a1) begin dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_LATCH; end
            end
            5'd1: begin
                if (a0) begin dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_SNAP_CNT; end
                else if (a1) begin dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_ORC; end
                else if (a2) begin dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_SNAP; end
            end
            5'd2: begin
                if (a1) begin
                    dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_LATCH; dec.clr_latch = 1'b1;
                end
            end
            5'd4: begin
                if (a0) begin
                    dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_SNAP_CNT; dec.clr_acnt = 1'b1;
                end else if (a1) begin
                    dec.x = 1'b1; dec.q = 1'b1; dec.rsel = RS_ORC; dec.clr_orc = 1'b1;
                end
            end
            5'd8: begin
                if (a0) begin dec.x = 1'b1; dec.q = attn; end
            end
            5'd9: begin
                if (a1) begin dec.x = 1'b1; dec.q = 1'b1; dec.clr_latch = 1'b1; end
            end
            5'd10: begin
                if (a0) begin dec.x = 1'b1; dec.q = 1'b1; dec.attn_rst = 1'b1; end
            end
            5'd11: begin
                if (a0) begin dec.x = 1'b1; dec.q = 1'b1; dec.clr_acnt = 1'b1; end
                else if (a1) begin dec.x = 1'b1; dec.q = 1'b1; dec.clr_orc = 1'b1; end
            end
            5'd16: begin
                if (a0) begin dec.x = 1'b1; dec.q = remote; dec.wr_mask = remote; end
            end
            5'd26: begin
                if (a0) begin dec.x = 1'b1; dec.q = 1'b1; dec.attn_en = 1'b1; end
            end
            5'd28: begin
                if (a0) begin
                    dec.x = 1'b1; dec.q = 1'b1; dec.attn_rst = 1'b1; dec.attn_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dw_rd_mux.sv
module dw_rd_mux
    import dw_cmd_pkg::*;
#(
    parameter int MASK_W  = 8,
    parameter int CNT_W   = 8,
    parameter int LATCH_W = 16,
    parameter int ORC_W   = 16,
    parameter int DATA_W  = 16
) (
    input  rsel_e              rsel,
    input  logic [MASK_W-1:0]  mask,
    input  logic [MASK_W-1:0]  snap,
    input  logic [CNT_W-1:0]   acnt,
    input  logic [LATCH_W-1:0] latch,
    input  logic [ORC_W-1:0]   orc,
    output logic [DATA_W-1:0]  data
);

    always_comb begin
        data = '0;
        case (rsel)
            RS_MASK:     data[MASK_W-1:0] = mask;
            RS_SNAP_CNT: begin
                data[MASK_W-1:0]     = snap;
                data[MASK_W +: CNT_W] = acnt;
            end
            RS_SNAP:     data[MASK_W-1:0]  = snap;
            RS_LATCH:    data[LATCH_W-1:0] = latch;
            RS_ORC:      data[ORC_W-1:0]   = orc;
            default:     ;
        endcase
    end

endmodule

// File: rtl/dw_mask_reg.sv
module dw_mask_reg #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_val,
    input  logic              remote,
    input  logic [MASK_W-1:0] sw,
    output logic [MASK_W-1:0] eff
);

    logic [MASK_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_val;
    end

    assign eff = remote ? mask_q : sw;

endmodule

// File: rtl/dw_cmd_decoder.sv
module dw_cmd_decoder
    import dw_cmd_pkg::*;
#(
    parameter int MASK_W  = 8,
    parameter int CNT_W   = 8,
    parameter int LATCH_W = 16,
    parameter int ORC_W   = 16,
    localparam int PACK_W = MASK_W + CNT_W,
    localparam int MAX_LO = (LATCH_W > ORC_W) ? LATCH_W : ORC_W,
    localparam int DATA_W = (PACK_W > MAX_LO) ? PACK_W : MAX_LO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_stb,
    input  logic [F_W-1:0]     cmd_f,
    input  logic [A_W-1:0]     cmd_a,
    input  logic [MASK_W-1:0]  wr_data,
    input  logic               remote_mode,
    input  logic [MASK_W-1:0]  sw_mask,
    input  logic               attn_present,
    input  logic [MASK_W-1:0]  snap_in,
    input  logic [CNT_W-1:0]   attn_cnt_in,
    input  logic [LATCH_W-1:0] latch_in,
    input  logic [ORC_W-1:0]   orc_in,
    output logic               rsp_valid,
    output logic               rsp_x,
    output logic               rsp_q,
    output logic [DATA_W-1:0]  rd_data,
    output logic [MASK_W-1:0]  mask_o,
    output logic               clr_latch_o,
    output logic               clr_orc_o,
    output logic               clr_acnt_o,
    output logic               attn_rst_o,
    output logic               attn_en_o
);

    state_e            state_q, state_d;
    dec_t              dec;
    logic [DATA_W-1:0] mux_data;
    logic              accept;
    logic              wr_mask_q;
    logic [MASK_W-1:0] wdata_q;

    dw_cmd_table u_table (
        .f      (cmd_f),
        .a      (cmd_a),
        .remote (remote_mode),
        .attn   (attn_present),
        .dec    (dec)
    );

    dw_rd_mux #(
        .MASK_W (MASK_W), .CNT_W (CNT_W), .LATCH_W (LATCH_W),
        .ORC_W  (ORC_W),  .DATA_W (DATA_W)
    ) u_mux (
        .rsel  (dec.rsel),
        .mask  (mask_o),
        .snap  (snap_in),
        .acnt  (attn_cnt_in),
        .latch (latch_in),
        .orc   (orc_in),
        .data  (mux_data)
    );

    dw_mask_reg #(.MASK_W (MASK_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_mask_q),
        .wr_val (wdata_q),
        .remote (remote_mode),
        .sw     (sw_mask),
        .eff    (mask_o)
    );

    assign accept = (state_q == ST_IDLE) && cmd_stb;

    // next-state logic: accept, finish, linger, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_stb) state_d = ST_RESP;
            ST_RESP: state_d = cmd_stb ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!cmd_stb) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered response outputs, live only in ST_RESP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_x       <= 1'b0;
            rsp_q       <= 1'b0;
            rd_data     <= '0;
            clr_latch_o <= 1'b0;
            clr_orc_o   <= 1'b0;
            clr_acnt_o  <= 1'b0;
            attn_rst_o  <= 1'b0;
            attn_en_o   <= 1'b0;
            wr_mask_q   <= 1'b0;
            wdata_q     <= '0;
        end else if (accept) begin
            rsp_valid   <= 1'b1;
            rsp_x       <= dec.x;
            rsp_q       <= dec.q;
            rd_data     <= mux_data;
            clr_latch_o <= dec.clr_latch;
            clr_orc_o   <= dec.clr_orc;
            clr_acnt_o  <= dec.clr_acnt;
            attn_rst_o  <= dec.attn_rst;
            attn_en_o   <= dec.attn_en;
            wr_mask_q   <= dec.wr_mask;
            wdata_q     <= wr_data;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_x       <= 1'b0;
            rsp_q       <= 1'b0;
            rd_data     <= '0;
            clr_latch_o <= 1'b0;
            clr_orc_o   <= 1'b0;
            clr_acnt_o  <= 1'b0;
            attn_rst_o  <= 1'b0;
            attn_en_o   <= 1'b0;
            wr_mask_q   <= 1'b0;
        end
    end

endmodule

// File: rtl/dw_cmd_decoder_chk.sv
module dw_cmd_decoder_chk #(
    parameter int MASK_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              remote_mode,
    input logic              rsp_valid,
    input logic              rsp_x,
    input logic              rsp_q,
    input logic [DATA_W-1:0] rd_data,
    input logic [MASK_W-1:0] mask_o,
    input logic              clr_latch_o,
    input logic              clr_orc_o,
    input logic              clr_acnt_o,
    input logic              attn_rst_o,
    input logic              attn_en_o
);

    logic any_stb;
    assign any_stb = clr_latch_o | clr_orc_o | clr_acnt_o | attn_rst_o | attn_en_o;

    p_one_cycle_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_x && !rsp_q && !any_stb && rd_data == '0));

    p_q_needs_x_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_q |-> rsp_x);

    p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_x) |-> (!any_stb && rd_data == '0));

    p_no_action_without_q_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_x && !rsp_q) |-> !any_stb);

    p_mask_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_mode && $past(remote_mode) && !$past(rsp_valid)) |-> (mask_o == $past(mask_o)));

endmodule

bind dw_cmd_decoder dw_cmd_decoder_chk #(
    .MASK_W (MASK_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .remote_mode (remote_mode),
    .rsp_valid   (rsp_valid),
    .rsp_x       (rsp_x),
    .rsp_q       (rsp_q),
    .rd_data     (rd_data),
    .mask_o      (mask_o),
    .clr_latch_o (clr_latch_o),
    .clr_orc_o   (clr_orc_o),
    .clr_acnt_o  (clr_acnt_o),
    .attn_rst_o  (attn_rst_o),
    .attn_en_o   (attn_en_o)
);

// File: tb/dw_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module dw_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [4:0]  cmd_f = '0;
    logic [3:0]  cmd_a = '0;
    logic [7:0]  wr_data = '0;
    logic        remote_mode = 1'b1;
    logic [7:0]  sw_mask = '0;
    logic        attn_present = 1'b0;
    logic [7:0]  snap_in = '0;
    logic [7:0]  attn_cnt_in = '0;
    logic [15:0] latch_in = '0;
    logic [15:0] orc_in = '0;
    logic        rsp_valid, rsp_x, rsp_q;
    logic [15:0] rd_data;
    logic [7:0]  mask_o;
    logic        clr_latch_o, clr_orc_o, clr_acnt_o, attn_rst_o, attn_en_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] mdl_mask = '0;

    always #4 clk = ~clk;

    dw_cmd_decoder dut_i (.*);

    function automatic string req_of(input int f, input int a);
        if (f == 0 && a == 0) return "R3";
        if (f == 16 && a == 0) return "R4";
        if ((f == 1 && (a == 0 || a == 2))) return "R5";
        if ((f == 0 || f == 2 || f == 9) && a == 1) return "R6";
        if ((f == 1 || f == 4 || f == 11) && a == 1) return "R7";
        if ((f == 4 || f == 11) && a == 0) return "R8";
        if ((f == 10 || f == 26 || f == 28) && a == 0) return "R9";
        if (f == 8 && a == 0) return "R10";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected {x,q,rd[15:0],clr_latch,clr_orc,clr_acnt,attn_rst,attn_en}
    function automatic logic [22:0] expect_of(input int f, input int a);
        logic x, q;
        logic [15:0] rd;
        logic [4:0] s;
        logic [7:0] em;
        em = remote_mode ? mdl_mask : sw_mask;
        x = 1'b1; rd = '0; s = '0;
        if (f == 0 && a == 0)       rd = {8'h00, em};
        else if (f == 0 && a == 1)  rd = latch_in;
        else if (f == 1 && a == 0)  rd = {attn_cnt_in, snap_in};
        else if (f == 1 && a == 1)  rd = orc_in;
        else if (f == 1 && a == 2)  rd = {8'h00, snap_in};
        else if (f == 2 && a == 1)  begin rd = latch_in; s = 5'b10000; end
        else if (f == 4 && a == 0)  begin rd = {attn_cnt_in, snap_in}; s = 5'b00100; end
        else if (f == 4 && a == 1)  begin rd = orc_in; s = 5'b01000; end
        else if (f == 8 && a == 0)  ;
        else if (f == 9 && a == 1)  s = 5'b10000;
        else if (f == 10 && a == 0) s = 5'b00010;
        else if (f == 11 && a == 0) s = 5'b00100;
        else if (f == 11 && a == 1) s = 5'b01000;
        else if (f == 16 && a == 0) ;
        else if (f == 26 && a == 0) s = 5'b00001;
        else if (f == 28 && a == 0) s = 5'b00011;
        else x = 1'b0;
        q = x;
        if (f == 16 && a == 0 && !remote_mode) q = 1'b0;
        if (f == 8 && a == 0 && !attn_present) q = 1'b0;
        return {x, q, rd, s};
    endfunction

    task automatic run_cmd(input int f, input int a, input int seed);
        logic [22:0] exp;
        logic [22:0] act;
        string req;
        @(negedge clk);
        cmd_f       = 5'(f);
        cmd_a       = 4'(a);
        wr_data     = 8'(seed * 37 + 11);
        sw_mask     = 8'(seed * 13) ^ 8'hC3;
        snap_in     = 8'(seed) ^ 8'h5A;
        attn_cnt_in = 8'(seed * 3 + 1);
        latch_in    = {8'(seed), ~8'(seed)};
        orc_in      = 16'(seed * 257 + 7);
        cmd_stb     = 1'b1;
        exp = expect_of(f, a);
        req = req_of(f, a);
        @(negedge clk);
        act = {rsp_x, rsp_q, rd_data, clr_latch_o, clr_orc_o, clr_acnt_o, attn_rst_o, attn_en_o};
        check({req, " R12 response"}, {9'd0, act}, {9'd0, exp});
        check("R2 valid in response cycle", {31'd0, rsp_valid}, 32'd1);
        cmd_stb = 1'b0;
        if (f == 16 && a == 0 && remote_mode) mdl_mask = wr_data;
        @(negedge clk);
        check("R2 valid dropped", {31'd0, rsp_valid}, 32'd0);
        if (f == 16 && a == 0)
            check(remote_mode ? "R4 mask written" : "R4 local mask untouched",
                  {24'd0, mask_o}, {24'd0, remote_mode ? mdl_mask : sw_mask});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs",
              {23'd0, rsp_valid, rsp_x, rsp_q, clr_latch_o, clr_orc_o, clr_acnt_o, attn_rst_o, attn_en_o, |rd_data},
              32'd0);
        check("R1 reset mask", {24'd0, mask_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // near-exhaustive sweep over every F/A in both modes and attention levels
        for (int m = 1; m >= 0; m--) begin
            for (int t = 0; t < 2; t++) begin
                @(negedge clk);
                remote_mode  = m[0];
                attn_present = t[0];
                for (int f = 0; f < 32; f++)
                    for (int a = 0; a < 16; a++)
                        run_cmd(f, a, f * 16 + a + t * 512 + m * 1024);
            end
        end

        // R3: mask mux follows mode
        @(negedge clk);
        remote_mode = 1'b1;
        #1 check("R3 remote mask view", {24'd0, mask_o}, {24'd0, mdl_mask});
        remote_mode = 1'b0;
        sw_mask = 8'hA5;
        #1 check("R3 local mask view", {24'd0, mask_o}, 32'h0000_00A5);
        remote_mode = 1'b1;

        // R2: strobe held high gives one response only (F28 A0, R9 strobes)
        begin
            int nv, nr, ne;
            nv = 0; nr = 0; ne = 0;
            @(negedge clk);
            cmd_f = 5'd28; cmd_a = 4'd0; cmd_stb = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                nv += rsp_valid; nr += attn_rst_o; ne += attn_en_o;
            end
            cmd_stb = 1'b0;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                nv += rsp_valid; nr += attn_rst_o; ne += attn_en_o;
            end
            check("R2 held strobe single response", 32'(nv), 32'd1);
            check("R9 held strobe single reset/enable", 32'(nr * 16 + ne), 32'd17);
        end
        // after release a new command is accepted again
        run_cmd(10, 0, 5);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule